// File: doc/BRIEF.md
# Up/Down Autoreload Timer with Capture

This block is a 16-bit timer/counter for a small controller, reached over an 8-bit register bus with a synchronous write strobe and a combinational read port. The count advances on every clock (timer mode) or on each falling edge of a synchronized external tick pin (counter mode). One 16-bit register pair is shared between two jobs. In capture mode it latches the running count on an external trigger. In autoreload mode it holds the value loaded on overflow.

In autoreload mode the direction comes from a down-count enable bit together with an external direction pin. The same pin serves as the trigger input in the other modes. A clock-output mode turns each overflow into a toggle of a square-wave output, giving half the overflow rate. In this mode the interrupt request is held low.

Top module: `updown_capture_timer`

## Requirements
- R1: After a synchronous active-high reset every register reads 0x00 except the mode register (0xC9), which reads 0xFC. `irq`, `clk_out` and `clk_out_en` are 0.
- R2: Register map: control 0xC8, mode 0xC9, reload/capture low 0xCA and high 0xCB, count low 0xCC and high 0xCD. All are written when `bus_we` is high at a rising clock edge, and read back combinationally on `bus_rdata`. Unmapped addresses read 0x00. Control bits: 7 overflow flag, 6 external flag, 5:4 read 0, 3 trigger enable, 2 run, 1 counter select (1 = count tick falls), 0 capture select. Mode bits: 1 clock-output enable, 0 down-count enable.
- R3: Mode register bits 7:2 always read 1, whatever is written.
- R4: In timer mode with run set, the count advances by one on every clock edge.
- R5: In counter mode, a falling edge of `tick_in` advances the count by one. A two-flop synchronizer and an edge register lie on the way, so the count changes at the second rising edge after the first edge that samples the low level.
- R6: Counting up in autoreload mode, a step from 0xFFFF loads the reload value and sets the overflow flag.
- R7: In capture mode, a step from 0xFFFF wraps to 0x0000 and sets the overflow flag. A synchronized falling edge of `ext_in` with the trigger enable set copies the count into the reload/capture pair and sets the external flag. A capture takes priority over a bus write to that pair in the same cycle.
- R8: In autoreload mode with the down-count enable set and synchronized `ext_in` low, the count decrements. When it equals the reload value, the next step loads 0xFFFF, sets the overflow flag and toggles the external flag. With the enable clear, the level of `ext_in` does not affect the direction.
- R9: In autoreload mode counting up, a synchronized falling edge of `ext_in` with the trigger enable set loads the reload value into the count and sets the external flag. With the trigger enable clear the edge has no effect.
- R10: Clock-output mode is active when the clock-output enable is 1 and counter select is 0. In this mode `clk_out_en` is 1, `clk_out` toggles on each overflow (reload as in R6), and `irq` stays 0 while the flags still set. Outside this mode `clk_out` holds its value.
- R11: Outside clock-output mode, `irq` is the OR of the overflow and external flags.
- R12: The flags change only by a control write or by a hardware event. A hardware set in the same cycle as a clearing write wins.
- R13: A bus write to a count byte replaces that byte for the cycle, taking priority over stepping and reloading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tick_in | input | 1 | External count input (counter mode) |
| ext_in | input | 1 | Capture/reload trigger and direction pin |
| clk_out | output | 1 | Square-wave output |
| clk_out_en | output | 1 | Drive enable for the square-wave pin |
| irq | output | 1 | Interrupt request |

## Verification
The properties on stepping, wrapping and capture assume that no register write lands in the cycle they observe. They therefore exclude cycles with `bus_we` high, and the stimulus makes its register writes between observed runs. The pins `tick_in` and `ext_in` are treated as asynchronous. The bench changes them only on falling clock edges and holds each level for several cycles, so every edge passes through the synchronizer exactly once. A behavioural model in the bench tracks the count, the pair, the flags and the square-wave output. It is compared on every clock and on every register read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [7:0] ADDR_CTRL = 8'hC8;
    localparam logic [7:0] ADDR_MODE = 8'hC9;
    localparam logic [7:0] ADDR_RLD0 = 8'hCA;
    localparam logic [7:0] ADDR_CNT0 = 8'hCC;
    localparam logic [5:0] MODE_RSV  = 6'h3F;

    typedef struct packed {
        logic ovf;
        logic ext;
        logic trig_en;
        logic run;
        logic cnt_sel;
        logic cap_sel;
    } ctrl_t;

    typedef struct packed {
        logic clk_oe;
        logic dn_en;
    } mode_t;

    typedef enum logic [1:0] {
        OP_RELOAD_UP = 2'd0,
        OP_RELOAD_DN = 2'd1,
        OP_CAPTURE   = 2'd2,
        OP_CLKOUT    = 2'd3
    } op_e;

    typedef struct packed {
        logic ovf;
        logic ext_set;
        logic ext_tog;
        logic capture;
    } evt_t;

    // Clock output needs timer mode; it forces autoreload behaviour.
    function automatic op_e pick_op(ctrl_t c, mode_t m, logic dir_level);
        if (m.clk_oe && !c.cnt_sel) return OP_CLKOUT;
        if (c.cap_sel)              return OP_CAPTURE;
        if (m.dn_en && !dir_level)  return OP_RELOAD_DN;
        return OP_RELOAD_UP;
    endfunction

    function automatic logic fell(logic prev, logic now);
        return prev & ~now;
    endfunction

    function automatic logic [7:0] ctrl_image(ctrl_t c);
        return {c.ovf, c.ext, 2'b00, c.trig_en, c.run, c.cnt_sel, c.cap_sel};
    endfunction

    function automatic logic [7:0] mode_image(mode_t m);
        return {MODE_RSV, m.clk_oe, m.dn_en};
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic prev
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign level = sh_q[STAGES-1];
    assign prev  = prev_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int W = 16,
    localparam int NB = W / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  op_e           op,
    input  logic          trig,
    input  logic [W-1:0]  reload,
    input  logic [NB-1:0] cnt_wr,
    input  logic [7:0]    wdata,
    output logic [W-1:0]  count,
    output evt_t          evt,
    output logic          clk_out
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] cnt_q, cnt_n;
    logic         clk_q, clk_tog;

    always_comb begin
        cnt_n   = cnt_q;
        evt     = '0;
        clk_tog = 1'b0;
        if (step) begin
            if (op == OP_RELOAD_DN) begin
                if (cnt_q == reload) begin
                    cnt_n       = ALL_ONES;
                    evt.ovf     = 1'b1;
                    evt.ext_tog = 1'b1;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end else if (cnt_q == ALL_ONES) begin
                cnt_n   = (op == OP_CAPTURE) ? '0 : reload;
                evt.ovf = 1'b1;
                clk_tog = (op == OP_CLKOUT);
            end else begin
                cnt_n = cnt_q + 1'b1;
            end
        end
        if (trig && op != OP_RELOAD_DN) begin
            evt.ext_set = 1'b1;
            if (op == OP_CAPTURE) evt.capture = 1'b1;
            else                  cnt_n = reload;
        end
        for (int i = 0; i < NB; i++) begin
            if (cnt_wr[i]) cnt_n[i*8 +: 8] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            if (clk_tog) clk_q <= ~clk_q;
        end
    end

    assign count   = cnt_q;
    assign clk_out = clk_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 16,
    localparam int NB = W / 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_we,
    input  logic [7:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    input  evt_t         evt,
    input  logic [W-1:0] count,
    output ctrl_t        ctrl,
    output mode_t        mode,
    output logic [W-1:0] reload,
    output logic [7:0]   bus_rdata
);
    ctrl_t        ctrl_q;
    mode_t        mode_q;
    logic [W-1:0] rld_q;
    logic [NB-1:0] rld_hit, cnt_hit;
    logic         wr_ctrl, wr_mode, ovf_n, ext_n;

    for (genvar g = 0; g < NB; g++) begin : g_dec
        assign rld_hit[g] = (bus_addr == 8'(ADDR_RLD0 + g));
        assign cnt_hit[g] = (bus_addr == 8'(ADDR_CNT0 + g));
    end

    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_mode = bus_we && (bus_addr == ADDR_MODE);

    // Hardware events are applied after the software write (set wins).
    always_comb begin
        ovf_n = (wr_ctrl ? bus_wdata[7] : ctrl_q.ovf) | evt.ovf;
        ext_n = ((wr_ctrl ? bus_wdata[6] : ctrl_q.ext) ^ evt.ext_tog) | evt.ext_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
            rld_q  <= '0;
        end else begin
            ctrl_q.ovf <= ovf_n;
            ctrl_q.ext <= ext_n;
            if (wr_ctrl) begin
                ctrl_q.trig_en <= bus_wdata[3];
                ctrl_q.run     <= bus_wdata[2];
                ctrl_q.cnt_sel <= bus_wdata[1];
                ctrl_q.cap_sel <= bus_wdata[0];
            end
            if (wr_mode) begin
                mode_q.clk_oe <= bus_wdata[1];
                mode_q.dn_en  <= bus_wdata[0];
            end
            if (evt.capture) begin
                rld_q <= count;
            end else begin
                for (int i = 0; i < NB; i++) begin
                    if (bus_we && rld_hit[i]) rld_q[i*8 +: 8] <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == ADDR_CTRL) bus_rdata = ctrl_image(ctrl_q);
        if (bus_addr == ADDR_MODE) bus_rdata = mode_image(mode_q);
        for (int i = 0; i < NB; i++) begin
            if (rld_hit[i]) bus_rdata = rld_q[i*8 +: 8];
            if (cnt_hit[i]) bus_rdata = count[i*8 +: 8];
        end
    end

    assign ctrl   = ctrl_q;
    assign mode   = mode_q;
    assign reload = rld_q;
endmodule

// File: rtl/updown_capture_timer.sv
module updown_capture_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tick_in,
    input  logic       ext_in,
    output logic       clk_out,
    output logic       clk_out_en,
    output logic       irq
);
    localparam int NB = CNT_W / 8;

    ctrl_t            ctrl_q;
    mode_t            mode_q;
    evt_t             evt;
    op_e              op;
    logic [CNT_W-1:0] cnt_q, rld_q;
    logic [NB-1:0]    cnt_wr;
    logic             tick_lvl, tick_prev, ext_lvl, ext_prev;
    logic             step, trig;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_tick_sync (
        .clk(clk), .rst(rst), .pin(tick_in), .level(tick_lvl), .prev(tick_prev)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst(rst), .pin(ext_in), .level(ext_lvl), .prev(ext_prev)
    );

    for (genvar g = 0; g < NB; g++) begin : g_cwr
        assign cnt_wr[g] = bus_we && (bus_addr == 8'(ADDR_CNT0 + g));
    end

    assign op   = pick_op(ctrl_q, mode_q, ext_lvl);
    assign step = ctrl_q.run && (ctrl_q.cnt_sel ? fell(tick_prev, tick_lvl) : 1'b1);
    assign trig = ctrl_q.trig_en && fell(ext_prev, ext_lvl);

    tmr_count_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .step(step), .op(op), .trig(trig),
        .reload(rld_q), .cnt_wr(cnt_wr), .wdata(bus_wdata),
        .count(cnt_q), .evt(evt), .clk_out(clk_out)
    );

    tmr_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .evt(evt), .count(cnt_q),
        .ctrl(ctrl_q), .mode(mode_q), .reload(rld_q), .bus_rdata(bus_rdata)
    );

    assign clk_out_en = (op == OP_CLKOUT);
    assign irq        = (ctrl_q.ovf | ctrl_q.ext) & ~clk_out_en;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_we,
    input logic [7:0]   bus_addr,
    input logic [7:0]   bus_rdata,
    input logic         irq,
    input logic         clk_out,
    input logic         clk_out_en,
    input logic [W-1:0] count,
    input logic [W-1:0] reload,
    input logic         ovf_flag,
    input op_e          op,
    input logic         step,
    input logic         trig
);
    localparam logic [W-1:0] ALL_ONES = '1;

    assert_mode_rsv_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_MODE) |-> (bus_rdata[7:2] == MODE_RSV));

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        clk_out_en |-> !irq);

    assert_clkout_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !clk_out_en |=> $stable(clk_out));

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !(bus_we && bus_addr == ADDR_CTRL)) |=> ovf_flag);

    assert_up_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RELOAD_UP && step && count == ALL_ONES && !bus_we)
        |=> (count == $past(reload)));

    assert_down_step_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RELOAD_DN && step && count != reload && !bus_we)
        |=> (count == W'($past(count) - 1'b1)));

    assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CAPTURE && trig && !bus_we) |=> (reload == $past(count)));
endmodule

bind updown_capture_timer tmr_checker #(.W(CNT_W)) u_tmr_checker (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .irq(irq), .clk_out(clk_out),
    .clk_out_en(clk_out_en), .count(cnt_q), .reload(rld_q),
    .ovf_flag(ctrl_q.ovf), .op(op), .step(step), .trig(trig)
);

// File: tb/test_updown_capture_timer.sv
module test_updown_capture_timer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic tick_in = 1'b1;
    logic ext_in = 1'b1;
    logic clk_out, clk_out_en, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    updown_capture_timer i_updown_capture_timer (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
        .ext_in(ext_in), .clk_out(clk_out), .clk_out_en(clk_out_en), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_cnt, m_rld;
    logic m_ovf, m_ext, m_te, m_run, m_cs, m_cap, m_coe, m_dn, m_clk;
    logic [2:0] th, eh;   // [0] newest pin sample

    function automatic logic m_co();
        return m_coe && !m_cs;
    endfunction

    always @(posedge clk) begin
        logic co, capm, dn, stp, trg, tf, ef, so, tg, se, cap;
        logic [15:0] n_cnt;
        if (rst) begin
            m_cnt = 0; m_rld = 0; m_ovf = 0; m_ext = 0; m_te = 0; m_run = 0;
            m_cs = 0; m_cap = 0; m_coe = 0; m_dn = 0; m_clk = 0; th = 0; eh = 0;
        end else begin
            co   = m_coe && !m_cs;
            capm = m_cap && !co;
            dn   = !co && !capm && m_dn && !eh[1];
            tf   = th[2] && !th[1];
            ef   = eh[2] && !eh[1];
            stp  = m_run && (m_cs ? tf : 1'b1);
            trg  = m_te && ef && !dn;
            n_cnt = m_cnt; so = 0; tg = 0; se = 0; cap = 0;
            if (stp) begin
                if (dn) begin
                    if (m_cnt == m_rld) begin n_cnt = 16'hFFFF; so = 1; tg = 1; end
                    else n_cnt = m_cnt - 16'd1;
                end else if (m_cnt == 16'hFFFF) begin
                    n_cnt = capm ? 16'h0000 : m_rld;
                    so = 1;
                    if (co) m_clk = !m_clk;
                end else n_cnt = m_cnt + 16'd1;
            end
            if (trg) begin
                se = 1;
                if (capm) cap = 1; else n_cnt = m_rld;
            end
            if (bus_we && bus_addr == 8'hCC) n_cnt[7:0]  = bus_wdata;
            if (bus_we && bus_addr == 8'hCD) n_cnt[15:8] = bus_wdata;
            if (cap) m_rld = m_cnt;
            else begin
                if (bus_we && bus_addr == 8'hCA) m_rld[7:0]  = bus_wdata;
                if (bus_we && bus_addr == 8'hCB) m_rld[15:8] = bus_wdata;
            end
            if (bus_we && bus_addr == 8'hC8) begin
                m_ovf = bus_wdata[7]; m_ext = bus_wdata[6]; m_te = bus_wdata[3];
                m_run = bus_wdata[2]; m_cs = bus_wdata[1]; m_cap = bus_wdata[0];
            end
            m_ovf = m_ovf | so;
            m_ext = (m_ext ^ tg) | se;
            if (bus_we && bus_addr == 8'hC9) begin
                m_coe = bus_wdata[1]; m_dn = bus_wdata[0];
            end
            m_cnt = n_cnt;
            th = {th[1:0], tick_in};
            eh = {eh[1:0], ext_in};
        end
    end

    function automatic logic [7:0] m_read(logic [7:0] a);
        case (a)
            8'hC8: return {m_ovf, m_ext, 2'b00, m_te, m_run, m_cs, m_cap};
            8'hC9: return {6'h3F, m_coe, m_dn};
            8'hCA: return m_rld[7:0];
            8'hCB: return m_rld[15:8];
            8'hCC: return m_cnt[7:0];
            8'hCD: return m_cnt[15:8];
            default: return 8'h00;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_model(logic [7:0] a, string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(tag, {8'h00, bus_rdata}, {8'h00, m_read(a)});
    endtask

    task automatic rd_lit(logic [7:0] a, logic [7:0] mask, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(tag, {8'h00, bus_rdata & mask}, {8'h00, exp});
    endtask

    // per-clock comparison of the outputs against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R11 irq", {15'd0, irq}, {15'd0, (m_ovf | m_ext) && !m_co()});
            check("R10 clk_out", {15'd0, clk_out}, {15'd0, m_clk});
            check("R10 clk_out_en", {15'd0, clk_out_en}, {15'd0, m_co()});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int toggles;
        logic last_clk;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_lit(8'hC8, 8'hFF, 8'h00, "R1 ctrl");
        rd_lit(8'hC9, 8'hFF, 8'hFC, "R1 mode");
        rd_lit(8'hCA, 8'hFF, 8'h00, "R1 rld lo");
        rd_lit(8'hCB, 8'hFF, 8'h00, "R1 rld hi");
        rd_lit(8'hCC, 8'hFF, 8'h00, "R1 cnt lo");
        rd_lit(8'hCD, 8'hFF, 8'h00, "R1 cnt hi");
        check("R1 outputs", {13'd0, irq, clk_out, clk_out_en}, 16'd0);

        // R2 register readback
        wr(8'hCA, 8'h5A); wr(8'hCB, 8'hA5); wr(8'hCC, 8'h12); wr(8'hCD, 8'h34);
        rd_lit(8'hCA, 8'hFF, 8'h5A, "R2 rld lo");
        rd_lit(8'hCB, 8'hFF, 8'hA5, "R2 rld hi");
        rd_lit(8'hCC, 8'hFF, 8'h12, "R2 cnt lo");
        rd_lit(8'hCD, 8'hFF, 8'h34, "R2 cnt hi");
        rd_lit(8'h10, 8'hFF, 8'h00, "R2 unmapped");
        wr(8'hC8, 8'h3B);
        rd_lit(8'hC8, 8'hFF, 8'h0B, "R2 ctrl");
        wr(8'hC8, 8'h00);

        // R3 reserved mode bits
        wr(8'hC9, 8'hFF);
        rd_lit(8'hC9, 8'hFF, 8'hFF, "R3 mode set");
        wr(8'hC9, 8'h00);
        rd_lit(8'hC9, 8'hFF, 8'hFC, "R3 mode clear");

        // R4 / R6 / R11 timer up with reload
        wr(8'hCA, 8'h34); wr(8'hCB, 8'h12);
        wr(8'hCC, 8'hF0); wr(8'hCD, 8'hFF);
        wr(8'hC8, 8'h04);
        idle(5);
        rd_model(8'hCC, "R4 count lo");
        idle(25);
        rd_model(8'hCC, "R6 count lo");
        rd_model(8'hCD, "R6 count hi");
        rd_lit(8'hCD, 8'hFF, 8'h12, "R6 reloaded hi");
        rd_lit(8'hC8, 8'h80, 8'h80, "R6 ovf flag");
        check("R11 irq high", {15'd0, irq}, 16'd1);

        // R12 sticky flags, cleared by write
        idle(20);
        rd_lit(8'hC8, 8'h80, 8'h80, "R12 still set");
        wr(8'hC8, 8'h00);
        rd_lit(8'hC8, 8'hFF, 8'h00, "R12 cleared");
        check("R11 irq low", {15'd0, irq}, 16'd0);

        // R13 count write beats stepping
        wr(8'hCD, 8'h20);
        wr(8'hC8, 8'h04);
        idle(3);
        wr(8'hCC, 8'h55);
        rd_lit(8'hCC, 8'hFF, 8'h56, "R13 write then step");
        rd_model(8'hCD, "R13 count hi");

        // R5 counter mode
        wr(8'hC8, 8'h00);
        wr(8'hCC, 8'h00); wr(8'hCD, 8'h00);
        wr(8'hC8, 8'h06);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); tick_in = 1'b0;
            idle(3);
            tick_in = 1'b1;
            idle(3);
        end
        idle(4);
        rd_lit(8'hCC, 8'hFF, 8'h05, "R5 tick count");
        rd_model(8'hCD, "R5 count hi");

        // R7 capture
        wr(8'hC8, 8'h00);
        wr(8'hCC, 8'h00); wr(8'hCD, 8'h01);
        wr(8'hC8, 8'h0D);
        idle(5);
        ext_in = 1'b0;
        idle(6);
        ext_in = 1'b1;
        rd_model(8'hCA, "R7 capture lo");
        rd_model(8'hCB, "R7 capture hi");
        rd_lit(8'hCB, 8'hFF, 8'h01, "R7 capture hi lit");
        rd_lit(8'hC8, 8'h40, 8'h40, "R7 ext flag");
        wr(8'hC8, 8'h00);
        wr(8'hCC, 8'hFE); wr(8'hCD, 8'hFF);
        wr(8'hC8, 8'h05);
        idle(4);
        rd_model(8'hCC, "R7 wrap lo");
        rd_lit(8'hCD, 8'hFF, 8'h00, "R7 wrap hi");
        rd_lit(8'hC8, 8'h80, 8'h80, "R7 ovf flag");

        // R8 down counting
        wr(8'hC8, 8'h00);
        wr(8'hC9, 8'h01);
        wr(8'hCA, 8'h05); wr(8'hCB, 8'h00);
        wr(8'hCC, 8'h08); wr(8'hCD, 8'h00);
        ext_in = 1'b0;
        idle(4);
        wr(8'hC8, 8'h04);
        idle(10);
        rd_model(8'hCC, "R8 down lo");
        rd_lit(8'hCD, 8'hFF, 8'hFF, "R8 down hi");
        rd_lit(8'hC8, 8'hC0, 8'hC0, "R8 flags");
        ext_in = 1'b1;
        idle(6);
        rd_model(8'hCC, "R8 up again lo");
        rd_model(8'hCD, "R8 up again hi");
        wr(8'hC8, 8'h00);
        wr(8'hC9, 8'h00);
        wr(8'hCC, 8'h10); wr(8'hCD, 8'h00);
        ext_in = 1'b0;
        idle(4);
        wr(8'hC8, 8'h04);
        idle(5);
        rd_model(8'hCC, "R8 pin ignored lo");
        rd_lit(8'hCD, 8'hFF, 8'h00, "R8 pin ignored hi");

        // R9 external reload
        wr(8'hC8, 8'h00);
        wr(8'hCA, 8'h00); wr(8'hCB, 8'h40);
        wr(8'hCC, 8'h10); wr(8'hCD, 8'h00);
        ext_in = 1'b1;
        idle(4);
        wr(8'hC8, 8'h0C);
        idle(3);
        ext_in = 1'b0;
        idle(5);
        ext_in = 1'b1;
        rd_model(8'hCC, "R9 reload lo");
        rd_lit(8'hCD, 8'hFF, 8'h40, "R9 reload hi");
        rd_lit(8'hC8, 8'h40, 8'h40, "R9 ext flag");
        wr(8'hC8, 8'h04);
        wr(8'hCD, 8'h00);
        ext_in = 1'b0;
        idle(5);
        ext_in = 1'b1;
        idle(2);
        rd_lit(8'hC8, 8'hFF, 8'h04, "R9 disabled flags");
        rd_lit(8'hCD, 8'hFF, 8'h00, "R9 disabled count");

        // R10 clock output
        wr(8'hC8, 8'h00);
        wr(8'hC9, 8'h02);
        wr(8'hCA, 8'hF0); wr(8'hCB, 8'hFF);
        wr(8'hCC, 8'hF0); wr(8'hCD, 8'hFF);
        wr(8'hC8, 8'h04);
        toggles = 0;
        last_clk = clk_out;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (clk_out !== last_clk) toggles++;
            last_clk = clk_out;
        end
        check("R10 toggles seen", {15'd0, toggles >= 5}, 16'd1);
        check("R10 irq gated", {15'd0, irq}, 16'd0);
        check("R10 pin enabled", {15'd0, clk_out_en}, 16'd1);
        rd_lit(8'hC8, 8'h80, 8'h80, "R10 ovf flag still set");
        wr(8'hC9, 8'h00);
        check("R10 pin released", {15'd0, clk_out_en}, 16'd0);
        check("R11 irq after mode off", {15'd0, irq}, 16'd1);

        idle(2);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule